// File: doc/BRIEF.md
# Double-Buffered PWM Compare Timer

This block is one channel of a 16-bit timer that makes a pulse-width-modulated waveform. A free-running counter is compared with a compare value. The counter runs in one of two ways. In up/down mode it climbs from zero to a programmable ceiling and then falls back to zero, which gives phase-correct PWM. In overflow mode it climbs to the ceiling and wraps to zero, which gives single-slope PWM. A waveform stage moves the output pin to a high or low level when a compare event occurs. A two-bit output-mode field picks non-inverting, inverting or disconnected behaviour.

Software writes the compare value through a synchronous register port. The write goes into a holding register and not into the comparator. The comparator's active copy is loaded from the holding register only at the point in the count cycle where the counter sits at the ceiling. In up/down mode that point is the turn-around. In overflow mode it is the wrap. A new duty cycle therefore never cuts a pulse short part-way through. Reading the register port always returns the holding register, which is the value most recently written.

The counter is a two-state machine. In `DIR_UP` (rising) it increments. The transition *peak* moves it to `DIR_DOWN` (falling) when the count reaches the ceiling in up/down mode. The transition *floor* moves it back to `DIR_UP` when the count reaches zero. The transition *single-slope* holds it in `DIR_UP` whenever overflow mode is selected. The output stage is a second two-state machine, `LVL_LOW` and `LVL_HIGH`. Its transitions are *set* (enter `LVL_HIGH`) and *clear* (enter `LVL_LOW`), and they fire only when the output-mode field connects the pin.

Top module: `pwm_dbuf_timer`

## Requirements
- R1: While `rst_n` is low, the count, the holding register, the active compare value and `pwm_out` are all zero, and the counter state is rising.
- R2: A cycle with `wr_en` high loads `wr_data` into the holding register. From the next cycle on, `rd_data` shows that value until the next write, whether or not a latch has happened.
- R3: With `mode_sel`=0 (up/down), `cnt_val` steps 0,1,…,TOP,TOP-1,…,1,0,1,… with period 2·TOP.
- R4: With `mode_sel`=1 (overflow), `cnt_val` steps 0,1,…,TOP,0,1,… with period TOP+1.
- R5: The active compare value takes the holding value only on a clock edge where the counter is at TOP, in rising state or in overflow mode. The compare made on that same edge still uses the old active value. A write made at any other time changes no output edge until that point.
- R6: In up/down mode with `com_sel`=2'b10 (non-inverting), when 0 < compare < TOP, a match while rising clears `pwm_out` and a match while falling sets it. With `com_sel`=2'b11 (inverting), the levels are swapped.
- R7: In overflow mode with `com_sel`=2'b10, the edge at TOP (the wrap) sets `pwm_out` and a match with the compare value clears it. With 2'b11 the levels are swapped.
- R8: In up/down mode, a match with compare value 0 drives the inactive level (low when non-inverting, high when inverting). A match with compare value TOP drives the active level. After the latch, the output is therefore steady.
- R9: In overflow mode, compare value TOP gives a steady active level. Compare value 0 gives an active level lasting exactly one cycle per period.
- R10: With `com_sel`=2'b00 or the reserved 2'b01, `pwm_out` keeps its current level on every edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the compare register |
| wr_data | input | 16 | Compare value to write |
| rd_data | output | 16 | Read-back of the holding register |
| mode_sel | input | 1 | 0 = up/down counting, 1 = overflow counting |
| com_sel | input | 2 | Output mode: 00 off, 01 reserved (off), 10 non-inverting, 11 inverting |
| top_val | input | 16 | Counter ceiling TOP |
| cnt_val | output | 16 | Current count |
| pwm_out | output | 1 | PWM output pin |

## Verification
Suppose the active compare register is loaded at the wrong moment. The output then switches at the wrong count within the same period, and a cycle-accurate reference model catches the first such misplaced edge on the cycle it occurs. A wrong counter state (wrong direction or a missed turn-around) shows on `cnt_val` on the very next cycle. A stuck or mis-levelled output state shows at the next compare event, at most one counter period later. Directed cases pin down the count at which edges fall before and after a mid-cycle write, the pulse widths per period, and the steady levels at the extreme compare values.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } cnt_dir_e;

    typedef enum logic {
        MODE_UPDOWN   = 1'b0,
        MODE_OVERFLOW = 1'b1
    } pwm_mode_e;

    typedef enum logic [1:0] {
        COM_OFF    = 2'b00,
        COM_RSVD   = 2'b01,
        COM_NONINV = 2'b10,
        COM_INV    = 2'b11
    } com_mode_e;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } out_lvl_e;

endpackage

// File: rtl/pwm_dir_counter.sv
module pwm_dir_counter
    import pwm_timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  pwm_mode_e    mode_i,
    input  logic [W-1:0] top_i,
    output logic [W-1:0] cnt_o,
    output logic         rising_o,
    output logic         at_top_o
);
    localparam logic [W-1:0] ONE = W'(1);

    cnt_dir_e     state_q, state_d;
    logic [W-1:0] cnt_q, cnt_d;
    logic         reach_top;

    assign reach_top = (cnt_q >= top_i);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DIR_UP;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state and count
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (mode_i == MODE_OVERFLOW) begin
            state_d = DIR_UP;                     // single-slope
            cnt_d   = reach_top ? '0 : cnt_q + ONE;
        end else begin
            unique case (state_q)
                DIR_UP: begin
                    if (reach_top) begin          // peak
                        state_d = DIR_DOWN;
                        cnt_d   = (cnt_q == '0) ? '0 : cnt_q - ONE;
                    end else begin
                        cnt_d   = cnt_q + ONE;
                    end
                end
                DIR_DOWN: begin
                    if (cnt_q == '0) begin        // floor
                        state_d = DIR_UP;
                        cnt_d   = cnt_q + ONE;
                    end else begin
                        cnt_d   = cnt_q - ONE;
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        cnt_o    = cnt_q;
        rising_o = (state_q == DIR_UP);
        at_top_o = reach_top && ((mode_i == MODE_OVERFLOW) || (state_q == DIR_UP));
    end

    // R4
    ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_OVERFLOW && cnt_q >= top_i) |=> (cnt_q == '0));

    // R3
    ud_fall_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_UPDOWN && state_q == DIR_DOWN && cnt_q != '0)
            |=> (cnt_q == $past(cnt_q) - ONE));

endmodule

// File: rtl/pwm_cmp_buffer.sv
module pwm_cmp_buffer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en_i,
    input  logic [W-1:0] wr_data_i,
    input  logic         latch_i,
    output logic [W-1:0] hold_o,
    output logic [W-1:0] active_o
);
    logic [W-1:0] hold_q;
    logic [W-1:0] active_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (wr_en_i) begin
            hold_q <= wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= '0;
        end else if (latch_i) begin
            active_q <= hold_q;
        end
    end

    assign hold_o   = hold_q;
    assign active_o = active_q;

    // R2
    hold_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (hold_q == $past(wr_data_i)));

    // R5
    latch_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_i |=> $stable(active_q));

endmodule

// File: rtl/pwm_wave_gen.sv
module pwm_wave_gen
    import pwm_timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  pwm_mode_e    mode_i,
    input  com_mode_e    com_i,
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] top_i,
    input  logic [W-1:0] active_i,
    input  logic         rising_i,
    input  logic         at_top_i,
    output logic         pwm_o
);
    out_lvl_e lvl_q, lvl_d;
    logic     match;
    logic     upd;
    logic     want_hi;
    logic     inv;
    logic     connected;

    assign match     = (cnt_i == active_i);
    assign inv       = (com_i == COM_INV);
    assign connected = (com_i == COM_NONINV) || (com_i == COM_INV);

    // compare event decode, expressed for the non-inverting sense
    always_comb begin
        upd     = 1'b0;
        want_hi = 1'b0;
        if (mode_i == MODE_OVERFLOW) begin
            if (at_top_i) begin
                upd     = 1'b1;
                want_hi = 1'b1;
            end else if (match) begin
                upd     = 1'b1;
                want_hi = 1'b0;
            end
        end else if (match) begin
            upd = 1'b1;
            if (active_i == '0) begin
                want_hi = 1'b0;
            end else if (active_i == top_i) begin
                want_hi = 1'b1;
            end else begin
                want_hi = !rising_i;
            end
        end
    end

    // next level: set / clear
    always_comb begin
        lvl_d = lvl_q;
        if (upd && connected) begin
            unique case (want_hi ^ inv)
                1'b1: lvl_d = LVL_HIGH;
                1'b0: lvl_d = LVL_LOW;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= LVL_LOW;
        end else begin
            lvl_q <= lvl_d;
        end
    end

    // output
    always_comb begin
        pwm_o = (lvl_q == LVL_HIGH);
    end

    // R10
    com_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!connected) |=> $stable(pwm_o));

    // R7
    ovf_wrap_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_OVERFLOW && at_top_i && com_i == COM_NONINV) |=> pwm_o);

    // R8
    ud_zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_UPDOWN && com_i == COM_NONINV && match && active_i == '0)
            |=> !pwm_o);

endmodule

// File: rtl/pwm_dbuf_timer.sv
module pwm_dbuf_timer
    import pwm_timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] rd_data,
    input  logic         mode_sel,
    input  logic [1:0]   com_sel,
    input  logic [W-1:0] top_val,
    output logic [W-1:0] cnt_val,
    output logic         pwm_out
);
    pwm_mode_e    mode;
    com_mode_e    com;
    logic [W-1:0] cnt;
    logic [W-1:0] active_cmp;
    logic         rising;
    logic         at_top;

    assign mode = pwm_mode_e'(mode_sel);
    assign com  = com_mode_e'(com_sel);

    pwm_dir_counter #(.W(W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i   (mode),
        .top_i    (top_val),
        .cnt_o    (cnt),
        .rising_o (rising),
        .at_top_o (at_top)
    );

    pwm_cmp_buffer #(.W(W)) u_buffer (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .latch_i   (at_top),
        .hold_o    (rd_data),
        .active_o  (active_cmp)
    );

    pwm_wave_gen #(.W(W)) u_wave (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i   (mode),
        .com_i    (com),
        .cnt_i    (cnt),
        .top_i    (top_val),
        .active_i (active_cmp),
        .rising_i (rising),
        .at_top_i (at_top),
        .pwm_o    (pwm_out)
    );

    assign cnt_val = cnt;

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |-> (cnt_val == '0 && rd_data == '0 && !pwm_out));

endmodule

// File: tb/tb_pwm_dbuf_timer.sv
`timescale 1ns/1ps
module tb_pwm_dbuf_timer;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] rd_data;
    logic         mode_sel = 1'b0;
    logic [1:0]   com_sel = 2'b10;
    logic [W-1:0] top_val = 16'd10;
    logic [W-1:0] cnt_val;
    logic         pwm_out;

    int    vectors = 0;
    int    miscompares = 0;
    bit    done = 1'b0;
    string out_tag = "R6";
    int    prev_cnt = 0;

    always #2.5 clk = ~clk;

    pwm_dbuf_timer #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .mode_sel(mode_sel), .com_sel(com_sel),
        .top_val(top_val), .cnt_val(cnt_val), .pwm_out(pwm_out)
    );

    // reference model built from the requirements
    logic [W-1:0] m_cnt, m_hold, m_act;
    logic         m_up, m_out;
    bit           t_at, t_upd, t_hi;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt <= '0; m_up <= 1'b1; m_hold <= '0; m_act <= '0; m_out <= 1'b0;
        end else begin
            t_at  = (m_cnt >= top_val) && (mode_sel || m_up);
            t_upd = 1'b0;
            t_hi  = 1'b0;
            if (mode_sel) begin
                if (t_at) begin t_upd = 1'b1; t_hi = 1'b1; end
                else if (m_cnt == m_act) begin t_upd = 1'b1; t_hi = 1'b0; end
            end else if (m_cnt == m_act) begin
                t_upd = 1'b1;
                if (m_act == '0) t_hi = 1'b0;
                else if (m_act == top_val) t_hi = 1'b1;
                else t_hi = !m_up;
            end
            if (t_upd && com_sel[1]) m_out <= t_hi ^ (com_sel == 2'b11);
            if (mode_sel) begin
                m_up  <= 1'b1;
                m_cnt <= (m_cnt >= top_val) ? '0 : m_cnt + 16'd1;
            end else if (m_up) begin
                if (m_cnt >= top_val) begin
                    m_up  <= 1'b0;
                    m_cnt <= (m_cnt == '0) ? '0 : m_cnt - 16'd1;
                end else m_cnt <= m_cnt + 16'd1;
            end else begin
                if (m_cnt == '0) begin m_up <= 1'b1; m_cnt <= 16'd1; end
                else m_cnt <= m_cnt - 16'd1;
            end
            if (t_at) m_act <= m_hold;
            if (wr_en) m_hold <= wr_data;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // one cycle: sample away from the active edge and compare with the model
    task automatic step();
        @(negedge clk);
        prev_cnt = int'(cnt_val);
        chk(cnt_val == m_cnt, mode_sel ? "R4 count" : "R3 count", int'(cnt_val), int'(m_cnt));
        chk(rd_data == m_hold, "R2 read-back", int'(rd_data), int'(m_hold));
        chk(pwm_out == m_out, out_tag, int'(pwm_out), int'(m_out));
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic write_cmp(input logic [W-1:0] v);
        wr_en = 1'b1; wr_data = v;
        step();
        wr_en = 1'b0;
    endtask

    task automatic setup(input bit md, input logic [1:0] cm, input int top, input int cmp);
        rst_n = 1'b0; mode_sel = md; com_sel = cm; top_val = W'(top);
        step(); step();
        rst_n = 1'b1;
        write_cmp(W'(cmp));
    endtask

    // run until the count shows v, moving in the requested direction
    task automatic run_to(input int v, input bit rising);
        int last;
        for (int i = 0; i < 400; i++) begin
            last = int'(cnt_val);
            step();
            if (int'(cnt_val) == v && ((int'(cnt_val) > last) == rising)) return;
        end
        chk(1'b0, "run_to timeout", int'(cnt_val), v);
    endtask

    task automatic count_high(input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin step(); if (pwm_out) hi++; end
    endtask

    task automatic count_changes(input int n, output int ch);
        logic first;
        ch = 0;
        first = pwm_out;
        for (int i = 0; i < n; i++) begin step(); if (pwm_out != first) ch++; end
    endtask

    initial begin
        int hi;
        int ch;
        int top;
        int cmp;
        logic held;
        void'($urandom(32'd7331));

        // R1: reset state
        rst_n = 1'b0; top_val = 16'd10;
        step(); step();
        chk(cnt_val == '0, "R1 count", int'(cnt_val), 0);
        chk(rd_data == '0, "R1 read", int'(rd_data), 0);
        chk(pwm_out == 1'b0, "R1 out", int'(pwm_out), 0);

        // R3: up/down sequence
        rst_n = 1'b1; mode_sel = 1'b0; top_val = 16'd5;
        for (int i = 1; i <= 14; i++) begin
            step();
            chk(int'(cnt_val) == (((i % 10) <= 5) ? (i % 10) : 10 - (i % 10)),
                "R3 sequence", int'(cnt_val), ((i % 10) <= 5) ? (i % 10) : 10 - (i % 10));
        end

        // R4: overflow sequence
        rst_n = 1'b0; step(); rst_n = 1'b1; mode_sel = 1'b1; top_val = 16'd6;
        for (int i = 1; i <= 16; i++) begin
            step();
            chk(int'(cnt_val) == (i % 7), "R4 sequence", int'(cnt_val), i % 7);
        end

        // R5 / R2: mid-cycle write takes effect only after the latch point
        out_tag = "R5";
        setup(1'b0, 2'b10, 10, 3);
        run_to(10, 1'b1);
        run_to(1, 1'b1);
        write_cmp(16'd7);
        chk(rd_data == 16'd7, "R2 pending read-back", int'(rd_data), 7);
        run_to(5, 1'b1);
        chk(pwm_out == 1'b0, "R5 old compare still active", int'(pwm_out), 0);
        write_cmp(16'd2);
        write_cmp(16'd7);
        chk(rd_data == 16'd7, "R2 last write wins", int'(rd_data), 7);
        run_to(5, 1'b0);
        chk(pwm_out == 1'b1, "R5 new compare after latch", int'(pwm_out), 1);

        // R6: up/down duty, non-inverting and inverting
        out_tag = "R6";
        setup(1'b0, 2'b10, 8, 3);
        steps(40);
        count_high(16, hi);
        chk(hi == 6, "R6 non-inverting high cycles", hi, 6);
        setup(1'b0, 2'b11, 8, 3);
        steps(40);
        count_high(16, hi);
        chk(hi == 10, "R6 inverting high cycles", hi, 10);

        // R7: overflow duty
        out_tag = "R7";
        setup(1'b1, 2'b10, 9, 4);
        steps(30);
        count_high(10, hi);
        chk(hi == 5, "R7 non-inverting high cycles", hi, 5);
        setup(1'b1, 2'b11, 9, 4);
        steps(30);
        count_high(10, hi);
        chk(hi == 5, "R7 inverting high cycles", hi, 5);

        // R8: up/down extremes give steady levels
        out_tag = "R8";
        setup(1'b0, 2'b10, 12, 0);
        steps(60);
        count_changes(72, ch);
        chk(ch == 0 && pwm_out == 1'b0, "R8 zero non-inverting steady low", int'(pwm_out) + 2*ch, 0);
        write_cmp(16'd12);
        steps(60);
        count_changes(72, ch);
        chk(ch == 0 && pwm_out == 1'b1, "R8 TOP non-inverting steady high", int'(pwm_out) + 2*ch, 1);
        setup(1'b0, 2'b11, 12, 0);
        steps(60);
        count_changes(72, ch);
        chk(ch == 0 && pwm_out == 1'b1, "R8 zero inverting steady high", int'(pwm_out) + 2*ch, 1);

        // R9: overflow extremes
        out_tag = "R9";
        setup(1'b1, 2'b10, 9, 9);
        steps(30);
        count_changes(30, ch);
        chk(ch == 0 && pwm_out == 1'b1, "R9 TOP steady high", int'(pwm_out) + 2*ch, 1);
        write_cmp(16'd0);
        steps(30);
        count_high(30, hi);
        chk(hi == 3, "R9 zero gives one-cycle pulse per period", hi, 3);

        // R10: disconnected output holds
        out_tag = "R10";
        setup(1'b0, 2'b10, 10, 4);
        steps(30);
        com_sel = 2'b00;
        held = pwm_out;
        count_changes(60, ch);
        chk(ch == 0 && pwm_out == held, "R10 off holds level", ch, 0);
        com_sel = 2'b01;
        count_changes(60, ch);
        chk(ch == 0 && pwm_out == held, "R10 reserved holds level", ch, 0);

        // constrained random segments
        for (int s = 0; s < 10; s++) begin
            top = int'($urandom_range(30, 4));
            setup(1'($urandom_range(1, 0)),
                  ($urandom_range(7, 0) == 0) ? 2'b01 : (($urandom_range(2, 0) == 0) ? 2'b00
                      : (($urandom_range(1, 0) == 0) ? 2'b10 : 2'b11)),
                  top, int'($urandom_range(top, 0)));
            out_tag = mode_sel ? "R7 random" : "R6 random";
            for (int c = 0; c < 600; c++) begin
                if ($urandom_range(7, 0) == 0) begin
                    case ($urandom_range(3, 0))
                        0: cmp = 0;
                        1: cmp = top;
                        default: cmp = int'($urandom_range(top, 0));
                    endcase
                    write_cmp(W'(cmp));
                end else begin
                    step();
                end
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        #900000;
        if (!done) begin
            done = 1'b1;
            vectors++;
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule